// File: doc/BRIEF.md
# Horizontal Sync Regenerator with Coast Control

This block conditions the horizontal sync that arrives from a video source before it reaches the display pipeline. It learns which phase of the incoming sync is the pulse by comparing how long the line spends high and how long it spends low. From then on it treats only the leading edge of that pulse as the timing event. For each leading edge it emits a clean output pulse whose length is a programmed number of pixel clocks and whose active level is chosen by a control bit.

The block also forms a coast indication. This tells the downstream clock generator to stop following the sync, for example during a vertical interval that carries no line pulses. The indication is taken either from an external pin of selectable polarity or from the vertical sync. While coast is active, new leading edges start no output pulse. The vertical sync is passed out with its own polarity control. A two-bit selector routes one of four sync views to a monitor output.

Top module: `hsync_regen_top`

## Requirements
- R1: The active phase of `hsync_in` is learned at each rising edge of the sampled input by comparing the high-sample and low-sample counts of the line just ended. The shorter phase is taken as the pulse. If the counts are equal, the previous decision is kept. After reset the pulse is taken as high.
- R2: Only the leading edge of the learned pulse starts an output pulse, and the trailing edge never does. With the input changed between clock edges, `hs_out` shows the active level after the second rising clock edge that follows the change.
- R3: Each output pulse lasts exactly `cfg_hs_width` clock cycles. A width of 0 produces no pulse, and a leading edge that arrives while a pulse is running is ignored.
- R4: When `cfg_hs_pol` is 1 the `hs_out` pulse is high on an idle-low line. When it is 0 the pulse is low on an idle-high line.
- R5: When `cfg_coast_src` is 0, `coast_out` is 1 while `coast_pin` equals `cfg_coast_pol`. When it is 1, `coast_out` is 1 while `vsync_in` is high. In both cases `coast_out` follows its source after two rising clock edges.
- R6: While `coast_out` is 1 no new `hs_out` pulse starts, but a pulse already running still completes its full programmed width.
- R7: `vs_out` equals the sampled `vsync_in` when `cfg_vs_pol` is 1 and its inverse when `cfg_vs_pol` is 0, one rising edge after the input changes.
- R8: `mon_out` is selected by `cfg_mon_sel`: 0 gives `sog_raw` unregistered, 1 gives `hsync_in` unregistered, 2 gives the regenerated pulse as active high, and 3 gives the sampled input corrected to active high by the learned polarity.
- R9: During reset no pulse is running, so `hs_out` sits at its idle level, and `coast_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Incoming horizontal sync, either polarity |
| vsync_in | input | 1 | Incoming vertical sync, active high |
| coast_pin | input | 1 | External coast request |
| sog_raw | input | 1 | Raw sliced sync-on-green |
| cfg_hs_pol | input | 1 | Output sync level: 1 active high |
| cfg_hs_width | input | 8 | Output pulse length in clocks |
| cfg_coast_pol | input | 1 | Active level of `coast_pin` |
| cfg_coast_src | input | 1 | Coast source: 0 pin, 1 vertical sync |
| cfg_vs_pol | input | 1 | Vertical output polarity: 1 pass, 0 invert |
| cfg_mon_sel | input | 2 | Monitor output select |
| hs_out | output | 1 | Regenerated horizontal sync |
| vs_out | output | 1 | Vertical sync output |
| coast_out | output | 1 | Coast indication to the clock generator |
| mon_out | output | 1 | Selected monitor view |

## Verification
The assertions assume that the control fields stay still while a line is in flight. They also assume that each sync level lasts at least two clocks, so that the sampled edges are distinct events. The stimulus changes configuration only while the scoreboard is disarmed and no output pulse is running. Every line holds each level for several clocks. After each change of input polarity, a few warm-up lines are run so that the learned polarity has settled before expected pulses are queued.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [1:0] {
    MON_SOG      = 2'd0,
    MON_HS_RAW   = 2'd1,
    MON_HS_REGEN = 2'd2,
    MON_HS_FILT  = 2'd3
  } mon_sel_e;
endpackage

// File: rtl/hsr_in_sample.sv
module hsr_in_sample #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q_n;
    always_comb q_n = din[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= 1'b0;
      else        q[g] <= q_n;
    end
  end
endmodule

// File: rtl/hsr_pol_det.sv
module hsr_pol_det #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_q,
  output logic active_low,
  output logic lead,
  output logic hs_filt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             hs_d;
  logic [CNT_W-1:0] hi_cnt, lo_cnt, hi_n, lo_n;
  logic             act_low_n, rise, fall;

  always_comb begin
    rise      = hs_q & ~hs_d;
    fall      = ~hs_q & hs_d;
    hi_n      = hi_cnt;
    lo_n      = lo_cnt;
    act_low_n = active_low;
    if (rise) begin
      if (hi_cnt > lo_cnt)      act_low_n = 1'b1;
      else if (lo_cnt > hi_cnt) act_low_n = 1'b0;
      hi_n = {{(CNT_W-1){1'b0}}, 1'b1};
      lo_n = '0;
    end else if (hs_q) begin
      if (hi_cnt != CNT_MAX) hi_n = hi_cnt + 1'b1;
    end else begin
      if (lo_cnt != CNT_MAX) lo_n = lo_cnt + 1'b1;
    end
    lead    = active_low ? fall : rise;
    hs_filt = hs_q ^ active_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d       <= 1'b0;
      hi_cnt     <= '0;
      lo_cnt     <= '0;
      active_low <= 1'b0;
    end else begin
      hs_d       <= hs_q;
      hi_cnt     <= hi_n;
      lo_cnt     <= lo_n;
      active_low <= act_low_n;
    end
  end

  // R1: the learned polarity only moves at a sampled rising edge
  a_r1_hold_between_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && !hs_d) |=> $stable(active_low));
endmodule

// File: rtl/hsr_pulse_gen.sv
module hsr_pulse_gen #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead,
  input  logic             coast,
  input  logic [WID_W-1:0] width,
  output logic             active
);
  logic [WID_W-1:0] cnt, cnt_n;
  logic             busy, start;

  always_comb begin
    busy  = (cnt != '0);
    start = lead & ~coast & ~busy;
    cnt_n = cnt;
    if (busy)       cnt_n = cnt - 1'b1;
    else if (start) cnt_n = width;
    active = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R3: an accepted leading edge loads the programmed width
  a_r3_load_width: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && !coast && cnt == '0) |=> (cnt == $past(width)));
  // R6: coast keeps an idle generator idle
  a_r6_coast_masks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (coast && cnt == '0) |=> (cnt == '0));
  // R6: a running pulse always counts down to completion
  a_r6_pulse_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/hsr_coast_sel.sv
module hsr_coast_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_q,
  input  logic vs_q,
  input  logic pol,
  input  logic src,
  output logic coast
);
  logic coast_n;

  always_comb coast_n = src ? vs_q : (pin_q == pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coast <= 1'b0;
    else        coast <= coast_n;
  end

  // R5: a pin at its active level raises coast on the next edge
  a_r5_pin_coast: assert property (@(posedge clk) disable iff (!rst_n)
    (!src && pin_q == pol) |=> coast);
  // R5: a low vertical sync on the internal source clears coast
  a_r5_vs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (src && !vs_q) |=> !coast);
endmodule

// File: rtl/hsync_regen_top.sv
module hsync_regen_top #(
  parameter int CNT_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             coast_pin,
  input  logic             sog_raw,
  input  logic             cfg_hs_pol,
  input  logic [WID_W-1:0] cfg_hs_width,
  input  logic             cfg_coast_pol,
  input  logic             cfg_coast_src,
  input  logic             cfg_vs_pol,
  input  logic [1:0]       cfg_mon_sel,
  output logic             hs_out,
  output logic             vs_out,
  output logic             coast_out,
  output logic             mon_out
);
  import hsr_pkg::*;

  localparam int IDX_HS = 0;
  localparam int IDX_VS = 1;
  localparam int IDX_CP = 2;
  localparam int N_IN   = 3;

  logic [N_IN-1:0] in_q;
  logic            active_low, lead, hs_filt, regen;
  mon_sel_e        sel;

  hsr_in_sample #(.N(N_IN)) u_sample (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({coast_pin, vsync_in, hsync_in}),
    .q     (in_q)
  );

  hsr_pol_det #(.CNT_W(CNT_W)) u_pol (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_q       (in_q[IDX_HS]),
    .active_low (active_low),
    .lead       (lead),
    .hs_filt    (hs_filt)
  );

  hsr_coast_sel u_coast (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_q (in_q[IDX_CP]),
    .vs_q  (in_q[IDX_VS]),
    .pol   (cfg_coast_pol),
    .src   (cfg_coast_src),
    .coast (coast_out)
  );

  hsr_pulse_gen #(.WID_W(WID_W)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .lead   (lead),
    .coast  (coast_out),
    .width  (cfg_hs_width),
    .active (regen)
  );

  always_comb begin
    sel    = mon_sel_e'(cfg_mon_sel);
    hs_out = cfg_hs_pol ? regen : ~regen;
    vs_out = cfg_vs_pol ? in_q[IDX_VS] : ~in_q[IDX_VS];
    case (sel)
      MON_SOG:      mon_out = sog_raw;
      MON_HS_RAW:   mon_out = hsync_in;
      MON_HS_REGEN: mon_out = regen;
      default:      mon_out = hs_filt;
    endcase
  end

  // R4: with active-high output the output level is the pulse state
  a_r4_out_level: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hs_pol |-> (hs_out == u_pulse.active));
endmodule

// File: tb/hsync_regen_top_tb_top.sv
module hsync_regen_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hsync_in, vsync_in, coast_pin, sog_raw;
  logic       cfg_hs_pol, cfg_coast_pol, cfg_coast_src, cfg_vs_pol;
  logic [7:0] cfg_hs_width;
  logic [1:0] cfg_mon_sel;
  logic       hs_out, vs_out, coast_out, mon_out;

  int checks = 0;
  int errors = 0;
  int expq[$];
  bit mon_en = 0;
  int run_len = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hsync_regen_top dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .coast_pin(coast_pin), .sog_raw(sog_raw), .cfg_hs_pol(cfg_hs_pol),
    .cfg_hs_width(cfg_hs_width), .cfg_coast_pol(cfg_coast_pol),
    .cfg_coast_src(cfg_coast_src), .cfg_vs_pol(cfg_vs_pol),
    .cfg_mon_sel(cfg_mon_sel), .hs_out(hs_out), .vs_out(vs_out),
    .coast_out(coast_out), .mon_out(mon_out)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures each output pulse and compares with the scoreboard
  always @(negedge clk) begin
    if (!mon_en) run_len = 0;
    else if (hs_out == cfg_hs_pol) run_len++;
    else if (run_len > 0) begin
      if (expq.size() == 0) check(0, "R3 unexpected pulse", run_len, 0);
      else begin
        int e;
        e = expq.pop_front();
        check(run_len == e, "R3/R6 pulse width", run_len, e);
      end
      run_len = 0;
    end
  end

  // driver: one line; in_low selects the input pulse level
  task automatic line(int act_len, int idle_len, bit in_low, bit exp_pulse, bit chk_lat);
    hsync_in = in_low ? 1'b0 : 1'b1;
    if (exp_pulse && cfg_hs_width != 0) expq.push_back(int'(cfg_hs_width));
    for (int i = 0; i < act_len; i++) begin
      @(negedge clk);
      if (chk_lat && i == 1) begin
        check(hs_out == cfg_hs_pol, "R2 pulse after two edges", hs_out, cfg_hs_pol);
        if (cfg_mon_sel == 2'd2 || cfg_mon_sel == 2'd3)
          check(mon_out == 1'b1, "R8 monitor regen/filtered", mon_out, 1);
      end
    end
    hsync_in = in_low ? 1'b1 : 1'b0;
    repeat (idle_len) @(negedge clk);
  endtask

  task automatic settle(bit in_low);
    mon_en = 0;
    repeat (4) line(8, 60, in_low, 0, 0);
    expq.delete();
    mon_en = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; hsync_in = 0; vsync_in = 0; coast_pin = 0; sog_raw = 0;
    cfg_hs_pol = 1; cfg_hs_width = 8; cfg_coast_pol = 1; cfg_coast_src = 0;
    cfg_vs_pol = 1; cfg_mon_sel = 0;
    repeat (5) @(negedge clk);
    check(hs_out == 1'b0, "R9 reset hs_out idle", hs_out, 0);
    check(coast_out == 1'b0, "R9 reset coast_out", coast_out, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 default active-high input, R2 latency, R3 widths
    settle(0);
    repeat (3) line(10, 60, 0, 1, 1);
    cfg_hs_width = 1;  line(10, 60, 0, 1, 0);
    cfg_hs_width = 30; line(10, 60, 0, 1, 0);   // trailing edge inside pulse
    line(40, 60, 0, 1, 0);                       // long input pulse, no restart
    cfg_hs_width = 0;  repeat (2) line(10, 60, 0, 0, 0);

    // R4 active-low output
    mon_en = 0; cfg_hs_pol = 0; cfg_hs_width = 5;
    repeat (3) @(negedge clk);
    check(hs_out == 1'b1, "R4 idle high for active-low output", hs_out, 1);
    mon_en = 1;
    repeat (2) line(10, 60, 0, 1, 1);
    mon_en = 0; cfg_hs_pol = 1; repeat (3) @(negedge clk);

    // R1 active-low input learned; R8 filtered view
    cfg_hs_width = 6; cfg_mon_sel = 2'd3;
    hsync_in = 1; repeat (3) @(negedge clk);
    settle(1);
    repeat (2) line(6, 50, 1, 1, 1);
    // R1 tie keeps previous decision
    repeat (2) line(20, 20, 1, 1, 1);
    cfg_mon_sel = 2'd2;
    line(6, 50, 1, 1, 1);

    // back to active-high input
    cfg_mon_sel = 2'd0; hsync_in = 0; repeat (3) @(negedge clk);
    settle(0);

    // R5/R6 coast from pin
    coast_pin = 1; repeat (3) @(negedge clk);
    check(coast_out == 1'b1, "R5 pin coast active", coast_out, 1);
    repeat (2) line(10, 60, 0, 0, 0);
    coast_pin = 0; repeat (3) @(negedge clk);
    check(coast_out == 1'b0, "R5 pin coast released", coast_out, 0);
    line(10, 60, 0, 1, 1);
    cfg_coast_pol = 0; coast_pin = 1; repeat (3) @(negedge clk);
    check(coast_out == 1'b0, "R5 inverted pin inactive", coast_out, 0);
    coast_pin = 0; repeat (3) @(negedge clk);
    check(coast_out == 1'b1, "R5 inverted pin active", coast_out, 1);
    line(10, 60, 0, 0, 0);
    coast_pin = 1; cfg_coast_pol = 1; coast_pin = 0; repeat (3) @(negedge clk);

    // R6 running pulse completes under coast
    cfg_hs_width = 30;
    hsync_in = 1; expq.push_back(30);
    repeat (4) @(negedge clk);
    coast_pin = 1;
    repeat (6) @(negedge clk);
    hsync_in = 0;
    repeat (50) @(negedge clk);
    coast_pin = 0; repeat (3) @(negedge clk);

    // R5 coast from vertical sync
    cfg_coast_src = 1; cfg_hs_width = 8;
    vsync_in = 1; @(negedge clk);
    check(vs_out == 1'b1, "R7 vs_out passes", vs_out, 1);
    cfg_vs_pol = 0; #1;
    check(vs_out == 1'b0, "R7 vs_out inverted", vs_out, 0);
    cfg_vs_pol = 1;
    repeat (2) @(negedge clk);
    check(coast_out == 1'b1, "R5 vsync coast active", coast_out, 1);
    line(10, 60, 0, 0, 0);
    vsync_in = 0; repeat (3) @(negedge clk);
    check(coast_out == 1'b0, "R5 vsync coast released", coast_out, 0);
    line(10, 60, 0, 1, 1);

    // R8 raw views
    cfg_mon_sel = 2'd0; sog_raw = 1; #1;
    check(mon_out == 1'b1, "R8 sog view high", mon_out, 1);
    sog_raw = 0; #1;
    check(mon_out == 1'b0, "R8 sog view low", mon_out, 0);
    cfg_mon_sel = 2'd1; hsync_in = 0; #1;
    check(mon_out == 1'b0, "R8 raw hsync view", mon_out, 0);

    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R3 all queued pulses seen", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule